// File: doc/BRIEF.md
# Four-Pin Bidirectional Port with Direction Control

This block is a memory-mapped general-purpose I/O port with four pins. The pins sit in bits 7..4 of an 8-bit data register, and a direction register uses the same bit positions. A simple synchronous register bus reaches both registers. The bus has a one-bit register select, a write strobe, write data and combinational read data. Each pin drives a tristate pad through two controls: an output value and an output enable.

Reading the data register returns the levels on the pins, not the output latch. The pin levels first pass through a two-flop synchronizer. A separate bit command sets or clears a single bit. It does this by taking the current read value of the selected register, changing the one target bit, and writing the whole nibble back. On the data register this means a pin that is an input carries its external level into the latch.

Pin 6 can only pull low: its driver is open-drain. The other three pins drive both levels. Each pin has an analog-select input. While it is 1, that pin reads as 0, but its driver still follows the direction bit.

Top module: `gpio_nibble_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the direction bits are set to 1. After reset the direction register reads 0xF0 and every `pad_oe` bit is 0. The output latch is not reset.
- R2: Bits 3..0 of both registers always read 0. Writing those bits has no effect.
- R3: A write with `bus_we`=1 takes effect at the next clock edge. `bus_addr`=0 writes bits 7..4 into the output latch. `bus_addr`=1 writes them into the direction register.
- R4: A pin whose direction bit is 1 (input) has `pad_oe` at 0. A push-pull pin whose direction bit is 0 has `pad_oe` at 1 and `pad_out` equal to its latch bit. Pad index k belongs to register bit k+4.
- R5: Pin 6 (pad index 2) is open-drain. Its `pad_out` is always 0. Its `pad_oe` is 1 only when its direction bit is 0 and its latch bit is 0.
- R6: With `bus_addr`=0, `bus_rdata[7:4]` shows `pad_in` as it was two clocks earlier. A data write changes only the latch; the read value follows the pins.
- R7: While `ana_sel[k]` is 1, read bit k+4 of the data register is 0 whatever the pin level. The pad drive of that pin does not change.
- R8: A bit command (`bit_cmd`=1, `bus_we`=0, `bit_sel` in 4..7, `bus_addr`=0) loads the latch with the current data read value, with bit `bit_sel` replaced by `bit_val`. An input pin's external level is therefore copied into its latch bit.
- R9: The same bit command with `bus_addr`=1 changes only direction bit `bit_sel` to `bit_val`.
- R10: A bit command with `bit_sel` in 0..3 changes nothing. When `bus_we` and `bit_cmd` are both 1, the write is performed and the bit command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Write strobe for a full-register write |
| bus_wdata | input | 8 | Write data, bits 7..4 used |
| bus_rdata | output | 8 | Read data of the selected register |
| bit_cmd | input | 1 | Single-bit read-modify-write command |
| bit_val | input | 1 | Value for the target bit (1 set, 0 clear) |
| bit_sel | input | 3 | Register bit index of the target bit |
| ana_sel | input | 4 | Per-pin analog select, masks the data read |
| pad_in | input | 4 | Pin levels seen at the pads |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |

## Verification
The bench goes after the read-modify-write hazard. It sets the latch of an input pin to 1 while the pin is held low from outside, then issues a bit command on a different pin. A design that merged the old latch instead of the pin levels would keep the 1 and drive the wrong level once the pin turns to an output. The bench also checks the following cases. The open-drain pin is released when its latch is 1; a design that drove it high would fight the external pull. The two-clock read lag is checked; a design that reads the latch would show a data write at once. The analog mask is checked; a design that gated the driver with it would drop the pad enable. Finally, a combined write and bit command must let the write win.

// File: rtl/gpio_port_pkg.sv
// Package: shared types of the four-pin port.
// Assumes: a one-bit register select on the bus.
package gpio_port_pkg;

    // Register chosen by the bus select bit.
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/gpio_port_sync.sv
// Module: gpio_port_sync
// Does: carries the pad levels through a chain of flops before readback.
// Assumes: SYNC_STAGES >= 1. The stages reset to zero.
module gpio_port_sync #(
    parameter int unsigned PORT_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pins_q
);

    logic [PORT_W-1:0] stg_q [SYNC_STAGES];
    logic              warm_q;

    // First stage samples the raw pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= pad_in;
    end

    // Further stages shift the sampled value along.
    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    endgenerate

    assign pins_q = stg_q[SYNC_STAGES-1];

    // Marks that at least one cycle has passed since reset (assertion support).
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    // R6: the first stage holds the pad level from one clock earlier.
    p_first_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> stg_q[0] == $past(pad_in));

endmodule

// File: rtl/gpio_port_regs.sv
// Module: gpio_port_regs
// Does: holds the output latch and the direction register. It applies full
//       writes and single-bit read-modify-write commands.
// Assumes: rd_pins is the masked data read value. Writes win over bit commands.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned PORT_W   = 4,
    parameter int unsigned PORT_LSB = 4,
    parameter int unsigned IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] wr_nib,
    input  logic              bit_cmd,
    input  logic              bit_val,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [PORT_W-1:0] rd_pins,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);

    logic [PORT_W-1:0] bit_mask;
    logic              bit_hit;
    logic              bit_go;
    logic [PORT_W-1:0] latch_rmw;
    logic [PORT_W-1:0] dir_rmw;

    // Decodes the target bit index into a one-hot nibble mask.
    always_comb begin
        for (int i = 0; i < PORT_W; i++) begin
            bit_mask[i] = (bit_sel == IDX_W'(PORT_LSB + i));
        end
    end

    assign bit_hit   = |bit_mask;
    assign bit_go    = bit_cmd && !bus_we && bit_hit;
    assign latch_rmw = bit_val ? (rd_pins | bit_mask) : (rd_pins & ~bit_mask);
    assign dir_rmw   = bit_val ? (dir_q | bit_mask) : (dir_q & ~bit_mask);

    // Output latch: no reset, loaded by a write or a bit command.
    always_ff @(posedge clk) begin
        if (bus_we && sel == SEL_DATA)      latch_q <= wr_nib;
        else if (bit_go && sel == SEL_DATA) latch_q <= latch_rmw;
    end

    // Direction register: every pin is an input out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dir_q <= '1;
        else if (bus_we && sel == SEL_DIR) dir_q <= wr_nib;
        else if (bit_go && sel == SEL_DIR) dir_q <= dir_rmw;
    end

    // R1: a reset edge leaves every pin an input.
    p_dir_reset_r1: assert property (@(posedge clk)
        !rst_n |=> dir_q == '1);

    // R3: a direction write lands on the next edge.
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_DIR) |=> dir_q == $past(wr_nib));

    // R8: a clear command on the data register leaves the target latch bit at 0.
    p_bitclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && !bit_val && sel == SEL_DATA) |=> (latch_q & $past(bit_mask)) == '0);

    // R10: an out-of-range bit command leaves the direction register alone.
    p_bit_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cmd && !bus_we && !bit_hit) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_port_pad.sv
// Module: gpio_port_pad
// Does: turns the latch and direction bits into a value and an enable for
//       each pad. The pins set in OD_MASK only ever pull low.
// Assumes: the pad buffer drives pad_out while pad_oe is 1.
module gpio_port_pad #(
    parameter int unsigned     PORT_W  = 4,
    parameter logic [PORT_W-1:0] OD_MASK = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            if (OD_MASK[i]) begin : g_od
                // Open-drain pin: pulls low, releases for a latch value of 1.
                always_comb begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = !dir_q[i] && !latch_q[i];
                end

                // R5: when enabled, the open-drain pad carries a latched 0.
                p_od_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    pad_oe[i] |-> (!latch_q[i] && !pad_out[i]));
            end else begin : g_pp
                // Push-pull pin: drives the latch bit when the pin is an output.
                always_comb begin
                    pad_out[i] = latch_q[i];
                    pad_oe[i]  = !dir_q[i];
                end
            end

            // R4: an input pin is never driven.
            p_input_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
                dir_q[i] |-> !pad_oe[i]);
        end
    endgenerate

endmodule

// File: rtl/gpio_nibble_port.sv
// Module: gpio_nibble_port (top)
// Does: a four-pin port in the upper nibble of an 8-bit register pair.
//       It reads pin levels through a synchronizer and masks analog pins.
// Assumes: the bus is synchronous. Reads are combinational on bus_addr.
module gpio_nibble_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned       PORT_W      = 4,
    parameter int unsigned       PORT_LSB    = 4,
    parameter int unsigned       REG_W       = 8,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [PORT_W-1:0] OD_MASK     = 4'b0100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_addr,
    input  logic                     bus_we,
    input  logic [REG_W-1:0]         bus_wdata,
    output logic [REG_W-1:0]         bus_rdata,
    input  logic                     bit_cmd,
    input  logic                     bit_val,
    input  logic [$clog2(REG_W)-1:0] bit_sel,
    input  logic [PORT_W-1:0]        ana_sel,
    input  logic [PORT_W-1:0]        pad_in,
    output logic [PORT_W-1:0]        pad_out,
    output logic [PORT_W-1:0]        pad_oe
);

    localparam int unsigned IDX_W = $clog2(REG_W);

    reg_sel_e          sel;
    logic [PORT_W-1:0] pins_q;
    logic [PORT_W-1:0] rd_pins;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic              unused_wdata;

    assign sel          = reg_sel_e'(bus_addr);
    assign rd_pins      = pins_q & ~ana_sel;
    assign unused_wdata = ^{bus_wdata[REG_W-1:PORT_LSB+PORT_W], bus_wdata[PORT_LSB-1:0]};

    gpio_port_sync #(
        .PORT_W      (PORT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .pins_q (pins_q)
    );

    gpio_port_regs #(
        .PORT_W   (PORT_W),
        .PORT_LSB (PORT_LSB),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .bus_we  (bus_we),
        .wr_nib  (bus_wdata[PORT_LSB +: PORT_W]),
        .bit_cmd (bit_cmd),
        .bit_val (bit_val),
        .bit_sel (bit_sel),
        .rd_pins (rd_pins),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_port_pad #(
        .PORT_W  (PORT_W),
        .OD_MASK (OD_MASK)
    ) u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Read mux: places the selected nibble, all other bits read 0.
    always_comb begin
        bus_rdata = '0;
        if (sel == SEL_DATA) bus_rdata[PORT_LSB +: PORT_W] = rd_pins;
        else                 bus_rdata[PORT_LSB +: PORT_W] = dir_q;
    end

    // R7: an analog-selected pin never reads 1.
    p_ana_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> (bus_rdata[PORT_LSB +: PORT_W] & ana_sel) == '0);

endmodule

// File: tb/sim_gpio_nibble_port.sv
module sim_gpio_nibble_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bit_cmd = 1'b0;
    logic       bit_val = 1'b0;
    logic [2:0] bit_sel = 3'd0;
    logic [3:0] ana_sel = 4'h0;
    logic [3:0] ext = 4'b0110;
    logic [3:0] pad_in;
    logic [3:0] pad_out;
    logic [3:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Pads: driven value when enabled, otherwise the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_nibble_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_cmd(bit_cmd),
        .bit_val(bit_val), .bit_sel(bit_sel), .ana_sel(ana_sel),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Reference model state.
    logic [3:0] m_dir = 4'hF;
    logic [3:0] m_latch = 4'h0;
    logic [3:0] m_known = 4'h0;
    logic [3:0] s1 = 4'h0;
    logic [3:0] s2 = 4'h0;
    logic [3:0] e_oe, e_out, lvl;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            if (i == 2) begin
                e_out[i] = 1'b0;
                e_oe[i]  = !m_dir[i] && m_known[i] && !m_latch[i];
            end else begin
                e_out[i] = m_latch[i];
                e_oe[i]  = !m_dir[i];
            end
            lvl[i] = (e_oe[i] && m_known[i]) ? e_out[i] : ext[i];
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir <= 4'hF;
            s1 <= 4'h0;
            s2 <= 4'h0;
        end else begin
            logic [3:0] t;
            int k;
            s1 <= lvl;
            s2 <= s1;
            if (bus_we) begin
                if (bus_addr) m_dir <= bus_wdata[7:4];
                else begin
                    m_latch <= bus_wdata[7:4];
                    m_known <= 4'hF;
                end
            end else if (bit_cmd && bit_sel >= 3'd4) begin
                k = int'(bit_sel) - 4;
                if (bus_addr) begin
                    t = m_dir;
                    t[k] = bit_val;
                    m_dir <= t;
                end else begin
                    t = s2 & ~ana_sel;
                    t[k] = bit_val;
                    m_latch <= t;
                    m_known <= 4'hF;
                end
            end
        end
    end

    // Compares the design with the model one time unit after every edge.
    always @(posedge clk) begin
        #1;
        if (run && !done) begin
            logic [7:0] e_rd;
            e_rd = bus_addr ? {m_dir, 4'h0} : {s2 & ~ana_sel, 4'h0};
            checks++;
            if (pad_oe !== e_oe) begin
                errors++;
                $display("FAIL R4 R5 pad_oe act=%b exp=%b", pad_oe, e_oe);
            end
            checks++;
            if (((pad_out ^ e_out) & e_oe & m_known) != 4'h0) begin
                errors++;
                $display("FAIL R4 pad_out act=%b exp=%b", pad_out, e_out);
            end
            checks++;
            if (bus_rdata !== e_rd) begin
                errors++;
                $display("FAIL R6 R7 rdata act=%h exp=%h", bus_rdata, e_rd);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bitc(input logic a, input logic v, input logic [2:0] s);
        bus_addr = a;
        bit_val = v;
        bit_sel = s;
        bit_cmd = 1'b1;
        @(negedge clk);
        bit_cmd = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=hung exp=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        run = 1'b1;

        // R1: reset state.
        rd(1'b1, v); chk("R1 dir reset", v, 8'hF0);
        chk("R1 no drive", {4'h0, pad_oe}, 8'h00);
        tick(2);
        // R6: pins 5 and 6 held high externally.
        rd(1'b0, v); chk("R6 pin read", v, 8'h60);
        chk("R2 low nibble", {4'h0, v[3:0]}, 8'h00);

        // R3 R2: write latch and direction, low bits ignored.
        wr(1'b0, 8'hC5);
        wr(1'b1, 8'h0F);
        rd(1'b1, v); chk("R2 dir low bits", v, 8'h00);
        chk("R4 enables", {4'h0, pad_oe}, 8'h0B);
        chk("R4 values", {4'h0, pad_out & 4'b1011}, 8'h08);
        chk("R5 od released", {7'h0, pad_oe[2]}, 8'h00);
        tick(2);
        rd(1'b0, v); chk("R6 driven read", v, 8'hC0);

        // R6 R5: latch write not seen at once; open-drain pulls low.
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R6 read lags", v, 8'hC0);
        chk("R5 od enable", {4'h0, pad_oe}, 8'h0F);
        chk("R5 od value", {7'h0, pad_out[2]}, 8'h00);
        tick(2);
        rd(1'b0, v); chk("R5 od pulled low", v, 8'h00);

        // R7: analog mask.
        wr(1'b0, 8'hF0);
        tick(2);
        rd(1'b0, v); chk("R6 all high", v, 8'hF0);
        ana_sel = 4'b1001;
        rd(1'b0, v); chk("R7 masked read", v, 8'h60);
        chk("R7 drive kept", {4'h0, pad_oe}, 8'h0B);
        ana_sel = 4'h0;

        // R8: read-modify-write copies an input pin's level into its latch.
        wr(1'b1, 8'h30);
        tick(2);
        rd(1'b0, v); chk("R8 pre read", v, 8'hE0);
        bitc(1'b0, 1'b0, 3'd7);
        wr(1'b1, 8'h00);
        chk("R8 corrupted latch", {4'h0, pad_out}, 8'h02);
        chk("R8 od released", {7'h0, pad_oe[2]}, 8'h00);

        // R9: bit command on the direction register.
        bitc(1'b1, 1'b1, 3'd7);
        rd(1'b1, v); chk("R9 dir bit set", v, 8'h80);

        // R10: ignored commands and write priority.
        bitc(1'b1, 1'b0, 3'd2);
        rd(1'b1, v); chk("R10 dir unchanged", v, 8'h80);
        bitc(1'b0, 1'b1, 3'd0);
        chk("R10 latch unchanged", {4'h0, pad_out}, 8'h02);
        bus_addr = 1'b1; bus_wdata = 8'h10; bus_we = 1'b1;
        bit_cmd = 1'b1; bit_val = 1'b1; bit_sel = 3'd5;
        @(negedge clk);
        bus_we = 1'b0; bit_cmd = 1'b0;
        rd(1'b1, v); chk("R10 write wins", v, 8'h10);

        tick(3);
        finish_run();
    end

endmodule